// File: doc/BRIEF.md
# FIFO-Coupled Word Transfer Engine

This block moves data words from a transmit queue to a receive queue, one word at a time. Each word goes either out through a serial exchange port toward a master shifter, which sends it and returns the word it received, or, in loopback mode, straight back to the receive side without touching the port. Every received word is cut down to the programmed word width before it is stored.

The engine starts a word only while it is enabled, not set up as a slave, the transmit queue holds data and the receive queue has room. If the receive queue fills, the engine stalls with transmit data still waiting, so no received word is ever lost. It resumes once the host reads a word out. Asking for slave operation raises an error flag and blocks all transfers.

Both queue sides are valid/ready streams. On the transmit side, `tx_ready` is a pop strobe. It is high only together with `tx_valid`, and only in a cycle where a word is taken. On the receive side, `rx_valid` stays high with stable `rx_data` until `rx_ready` is seen. Because a slot is reserved before each start, that wait is normally one cycle. A low `rx_ready` holds back every new start.

Top module: `xfer_engine`

## Requirements
- R1: After reset, `busy`, `tx_ready`, `xs_start` and `rx_valid` are all low.
- R2: A word is popped (`tx_ready` high) only in a cycle where the engine is idle, `cfg_enable` is 1, `cfg_slave_sel` is 0, `tx_valid` is 1 and `rx_ready` is 1.
- R3: While `rx_ready` is low, no word is popped. With the receive queue full, transfers halt with transmit words pending, and each host read lets exactly one more word through.
- R4: With `cfg_loopback` set at the pop, `xs_start` stays low and the popped word, masked, is offered on `rx_data` in the cycle after the pop.
- R5: Without loopback, `xs_start` pulses in the pop cycle with `xs_wdata` equal to the popped word, and the masked `xs_rdata` is offered on `rx_data` in the cycle after `xs_done`.
- R6: At most one exchange is outstanding: `xs_start` never rises while `busy` is high.
- R7: `cfg_width` holds the word length minus one. A stored word keeps bits 0 to `cfg_width` and has all higher bits zero.
- R8: `cfg_err` equals `cfg_enable` AND `cfg_slave_sel`, and no word is popped while it is high.
- R9: Clearing `cfg_enable` during an exchange lets that word complete and be pushed, but no further word is popped.
- R10: Each pop is followed by exactly one push, and the pushes keep the order of the pops.
- R11: `busy` is high from the cycle after a pop until the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Port enable |
| cfg_loopback | input | 1 | Return transmit word internally |
| cfg_slave_sel | input | 1 | Slave-mode request (unsupported) |
| cfg_width | input | SEL_W | Word length minus one |
| tx_valid | input | 1 | Transmit queue not empty |
| tx_data | input | DATA_W | Head word of the transmit queue |
| tx_ready | output | 1 | Pop strobe for the transmit queue |
| rx_valid | output | 1 | Received word offered |
| rx_data | output | DATA_W | Masked received word |
| rx_ready | input | 1 | Receive queue has room |
| xs_start | output | 1 | Exchange start pulse |
| xs_wdata | output | DATA_W | Word to send |
| xs_done | input | 1 | Exchange finished pulse |
| xs_rdata | input | DATA_W | Word received, valid with `xs_done` |
| busy | output | 1 | A word is in flight |
| cfg_err | output | 1 | Unsupported slave mode selected |

## Verification
The main path is run in port mode at exchange latencies of one and three cycles, and in loopback at two word widths. This tells apart data taken from the port from data taken from the queue head, and shows whether the mask is applied at the right width. A burst larger than the receive queue, drained one read at a time, separates correct stalling from overflow and from a dead stop. Slave selection and disabling mid-exchange each check a case where a transfer must be blocked or must still complete. Every cycle, a behavioural queue model predicts each output and compares it with the design.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_PUSH = 2'd2
  } xs_state_e;
endpackage

// File: rtl/xfer_mask.sv
module xfer_mask #(
  parameter int DATA_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  width_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam logic [SEL_W:0] IDX = (SEL_W+1)'(g);
    assign mask_o[g] = (IDX <= {1'b0, width_i});
  end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable_i,
  input  logic loopback_i,
  input  logic slave_i,
  input  logic tx_valid_i,
  input  logic rx_ready_i,
  input  logic done_i,
  output logic pop_o,
  output logic start_o,
  output logic load_lb_o,
  output logic load_port_o,
  output logic push_o,
  output logic busy_o,
  output logic err_o
);
  xs_state_e state_q, state_d;
  logic go;

  assign err_o       = enable_i & slave_i;
  assign go          = (state_q == XS_IDLE) & enable_i & ~slave_i & tx_valid_i & rx_ready_i;
  assign pop_o       = go;
  assign start_o     = go & ~loopback_i;
  assign load_lb_o   = go & loopback_i;
  assign load_port_o = (state_q == XS_WAIT) & done_i;
  assign push_o      = (state_q == XS_PUSH);
  assign busy_o      = (state_q != XS_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE: if (go) state_d = loopback_i ? XS_PUSH : XS_WAIT;
      XS_WAIT: if (done_i) state_d = XS_PUSH;
      XS_PUSH: if (rx_ready_i) state_d = XS_IDLE;
      default: state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= XS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/xfer_hold.sv
module xfer_hold #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lb_i,
  input  logic              load_port_i,
  input  logic [DATA_W-1:0] lb_word_i,
  input  logic [DATA_W-1:0] port_word_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           word_q <= '0;
    else if (load_lb_i)   word_q <= lb_word_i & mask_i;
    else if (load_port_i) word_q <= port_word_i & mask_i;
  end

  assign word_o = word_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_loopback,
  input  logic              cfg_slave_sel,
  input  logic [SEL_W-1:0]  cfg_width,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  output logic              xs_start,
  output logic [DATA_W-1:0] xs_wdata,
  input  logic              xs_done,
  input  logic [DATA_W-1:0] xs_rdata,
  output logic              busy,
  output logic              cfg_err
);
  logic [DATA_W-1:0] mask;
  logic load_lb, load_port;

  xfer_mask #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_mask (
    .width_i (cfg_width),
    .mask_o  (mask)
  );

  xfer_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (cfg_enable),
    .loopback_i  (cfg_loopback),
    .slave_i     (cfg_slave_sel),
    .tx_valid_i  (tx_valid),
    .rx_ready_i  (rx_ready),
    .done_i      (xs_done),
    .pop_o       (tx_ready),
    .start_o     (xs_start),
    .load_lb_o   (load_lb),
    .load_port_o (load_port),
    .push_o      (rx_valid),
    .busy_o      (busy),
    .err_o       (cfg_err)
  );

  xfer_hold #(.DATA_W(DATA_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_lb_i   (load_lb),
    .load_port_i (load_port),
    .lb_word_i   (tx_data),
    .port_word_i (xs_rdata),
    .mask_i      (mask),
    .word_o      (rx_data)
  );

  assign xs_wdata = tx_data;
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int DATA_W = 16,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_loopback,
  input logic              cfg_slave_sel,
  input logic [SEL_W-1:0]  cfg_width,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              xs_start,
  input logic              xs_done,
  input logic              busy
);
  logic [DATA_W-1:0] chk_mask;
  always_comb
    for (int i = 0; i < DATA_W; i++) chk_mask[i] = (i <= int'(cfg_width));

  p_pop_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && cfg_enable && !cfg_slave_sel && !busy));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> rx_ready);
  p_lb_no_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && cfg_loopback) |-> !xs_start);
  p_lb_push_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && cfg_loopback) |=> rx_valid);
  p_start_with_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xs_start |-> (tx_ready && !cfg_loopback));
  p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !xs_start);
  p_masked_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ((rx_data & ~chk_mask) == '0));
  p_slave_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_slave_sel) |-> !tx_ready);
  p_busy_after_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> busy);
  p_push_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  p_done_pushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rx_valid && xs_done) |=> rx_valid);
endmodule

bind xfer_engine xfer_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_enable    (cfg_enable),
  .cfg_loopback  (cfg_loopback),
  .cfg_slave_sel (cfg_slave_sel),
  .cfg_width     (cfg_width),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .rx_ready      (rx_ready),
  .xs_start      (xs_start),
  .xs_done       (xs_done),
  .busy          (busy)
);

// File: tb/xfer_engine_tb.sv
module xfer_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int RXD = 8;

  logic clk = 0, rst_n = 0;
  logic cfg_enable = 0, cfg_loopback = 0, cfg_slave_sel = 0;
  logic [3:0] cfg_width = 4'd15;
  logic tx_valid = 0, rx_ready = 1, xs_done = 0;
  logic [DW-1:0] tx_data = '0, xs_rdata = '0;
  logic tx_ready, rx_valid, xs_start, busy, cfg_err;
  logic [DW-1:0] rx_data, xs_wdata;

  xfer_engine #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_loopback(cfg_loopback),
    .cfg_slave_sel(cfg_slave_sel), .cfg_width(cfg_width), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .xs_start(xs_start), .xs_wdata(xs_wdata), .xs_done(xs_done),
    .xs_rdata(xs_rdata), .busy(busy), .cfg_err(cfg_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] txq[$], rxq[$];
  int ph = 0;            // model: 0 idle, 1 waiting for port, 2 offering word
  logic [DW-1:0] held = '0;
  int lat = 1, scnt = 0;
  logic [DW-1:0] sword = '0;
  logic s_pop, s_lb, s_done;
  logic [3:0] s_w;

  function automatic logic [DW-1:0] msk(input logic [3:0] w);
    return DW'((32'd1 << (int'(w) + 1)) - 1);
  endfunction
  function automatic logic [DW-1:0] resp(input logic [DW-1:0] w);
    return w ^ 16'hB5C3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // environment drive, per-cycle compare and model update
  initial begin
    forever begin
      @(negedge clk);
      tx_valid = (txq.size() > 0);
      tx_data  = (txq.size() > 0) ? txq[0] : '0;
      rx_ready = (rxq.size() < RXD);
      xs_done  = (scnt == 1);
      xs_rdata = (scnt == 1) ? resp(sword) : '0;
      #1;
      s_pop  = rst_n && ph == 0 && cfg_enable && !cfg_slave_sel && txq.size() > 0 && rxq.size() < RXD;
      s_lb   = cfg_loopback;
      s_done = xs_done;
      s_w    = cfg_width;
      if (rst_n) begin
        chk(tx_ready == s_pop, "R2/R3/R8 pop", int'(tx_ready), int'(s_pop));
        chk(xs_start == (s_pop && !s_lb), "R4/R5/R6 start", int'(xs_start), int'(s_pop && !s_lb));
        if (s_pop && !s_lb) chk(xs_wdata == txq[0], "R5 wdata", int'(xs_wdata), int'(txq[0]));
        chk(rx_valid == (ph == 2), "R10 push", int'(rx_valid), int'(ph == 2));
        if (ph == 2) chk(rx_data == held, "R4/R5/R7 data", int'(rx_data), int'(held));
        chk(busy == (ph != 0), "R11 busy", int'(busy), int'(ph != 0));
        chk(cfg_err == (cfg_enable && cfg_slave_sel), "R8 err", int'(cfg_err), int'(cfg_enable && cfg_slave_sel));
      end
      @(posedge clk);
      if (s_done) scnt = 0; else if (scnt > 1) scnt--;
      if (!rst_n) ph = 0;
      else if (ph == 2) begin rxq.push_back(held); ph = 0; end
      else if (ph == 1 && s_done) begin held = resp(sword) & msk(s_w); ph = 2; end
      else if (ph == 0 && s_pop) begin
        logic [DW-1:0] f;
        f = txq.pop_front();
        if (s_lb) begin held = f & msk(s_w); ph = 2; end
        else begin ph = 1; sword = f; scnt = lat; end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      if (txq.size() == 0 && rxq.size() == 0 && ph == 0) break;
      if (rxq.size() > 0) void'(rxq.pop_front());
      cyc(1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk(busy == 0 && tx_ready == 0 && xs_start == 0 && rx_valid == 0, "R1 reset", int'(busy), 0);

    // port mode, full width, latency 1
    cfg_enable = 1; lat = 1;
    txq.push_back(16'h1234); txq.push_back(16'hFFFF); txq.push_back(16'h0F0F);
    cyc(20);
    chk(rxq.size() == 3, "R10 count", rxq.size(), 3);
    if (rxq.size() == 3) chk(rxq[1] == resp(16'hFFFF), "R5 port word", int'(rxq[1]), int'(resp(16'hFFFF)));
    drain();

    // loopback, 8-bit words
    cfg_loopback = 1; cfg_width = 4'd7;
    for (int i = 0; i < 4; i++) txq.push_back(DW'(16'hA100 + i * 16'h0111));
    cyc(20);
    chk(rxq.size() == 4, "R4 count", rxq.size(), 4);
    if (rxq.size() == 4) chk(rxq[3] == 16'h0033, "R4/R7 order+mask", int'(rxq[3]), 16'h0033);
    drain();

    // port mode, 4-bit words, latency 3
    cfg_loopback = 0; cfg_width = 4'd3; lat = 3;
    txq.push_back(16'hC0DE); txq.push_back(16'h5A5A);
    cyc(20);
    if (rxq.size() == 2) chk(rxq[0] == (resp(16'hC0DE) & 16'h000F), "R7 narrow", int'(rxq[0]), int'(resp(16'hC0DE) & 16'h000F));
    else chk(0, "R7 narrow count", rxq.size(), 2);
    drain();

    // overflow stall
    cfg_loopback = 1; cfg_width = 4'd15;
    for (int i = 0; i < 10; i++) txq.push_back(DW'(i + 16'h8000));
    cyc(40);
    chk(rxq.size() == RXD && txq.size() == 2 && busy == 0, "R3 stall", txq.size(), 2);
    void'(rxq.pop_front());
    cyc(10);
    chk(rxq.size() == RXD && txq.size() == 1, "R3 one more", txq.size(), 1);
    chk(rxq[RXD-1] == 16'h8008, "R10 order", int'(rxq[RXD-1]), 16'h8008);
    drain();

    // slave request blocks everything
    cfg_loopback = 0; lat = 1; cfg_slave_sel = 1;
    txq.push_back(16'h7777);
    cyc(15);
    chk(txq.size() == 1 && rxq.size() == 0 && cfg_err == 1, "R8 blocked", txq.size(), 1);
    cfg_slave_sel = 0;
    cyc(10);
    chk(rxq.size() == 1, "R8 resumes", rxq.size(), 1);
    drain();

    // disable during an exchange
    lat = 3;
    txq.push_back(16'h1111); txq.push_back(16'h2222);
    for (int k = 0; k < 20 && ph != 1; k++) cyc(1);
    cfg_enable = 0;
    cyc(15);
    chk(rxq.size() == 1 && txq.size() == 1 && busy == 0, "R9 finish one", rxq.size(), 1);
    cfg_enable = 1;
    drain();
    chk(txq.size() == 0 && rxq.size() == 0, "R9 drained", txq.size(), 0);

    cyc(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule